// File: doc/BRIEF.md
# Windowed Keystream MAC Tag Accumulator

This block builds the running 32-bit integrity tag of a word-oriented stream-cipher MAC. It keeps three 32-bit keystream words, treated as one 96-bit window, and takes the message 64 bits at a time. It scans each chunk from its most significant bit downward. For every bit that is set, it folds into the tag the 32-bit slice of the window that starts at that bit's position. When the scan is done, it slides the window forward by two words. The oldest surviving word moves to the front, and two fresh words are requested in turn from an external keystream generator.

The scan handles `GROUP_BITS` message bits per clock, so a 64-bit chunk takes 64/`GROUP_BITS` scan cycles and then the two keystream fetches. A host can read the window and the tag at any time, which lets it save the context. While the block is idle, the host can also write them back, or clear the tag when the generator is restarted. Handling of the final partial length is left to the surrounding logic.

Top module: `zmac_accum`

## Requirements
- R1: After a synchronous reset, the tag and all three window words are zero, `msg_ready` is 1, and `ks_req` and `done` are 0.
- R2: Message bit 63−i of a chunk selects window offset i. Offset 0 is word w0 and offset 32 is word w1. Offsets 1..31 give (w0<<i)|(w1>>(32−i)), and offsets 33..63 give (w1<<(i−32))|(w2>>(64−i)).
- R3: The tag is XORed with every selected slice, and it carries over from chunk to chunk. A chunk with no bits set leaves the tag unchanged.
- R4: After a chunk is scanned, w0 takes the old w2. The first keystream word received goes into w1 and the second into w2.
- R5: Each chunk makes exactly two keystream requests. `ks_req` stays high until `ks_ack` is seen, and `done` is a one-cycle pulse in the cycle after the second word is accepted.
- R6: `msg_ready` is low from the acceptance of a chunk until `done`. A `msg_valid` that arrives in that time is ignored and has no effect on the tag.
- R7: The save view gives `win_pair` = {w0, w1}, `win_tail` = {32'b0, w2} and `tag_word` = {32'b0, tag}.
- R8: While idle, a write to `pair_we` loads w0 from bits 63..32 and w1 from bits 31..0. A write to `tail_we` loads w2 from bits 31..0, and a write to `tag_we` loads the tag from bits 31..0. While busy, all three writes are ignored.
- R9: `gen_restart` while idle clears the tag and leaves the window unchanged. It takes priority over `tag_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message chunk offered |
| msg_data | input | 64 | Message chunk, bit 63 scanned first |
| msg_ready | output | 1 | Block idle and able to take a chunk |
| ks_req | output | 1 | Request for one keystream word |
| ks_ack | input | 1 | Keystream word present on `ks_word` |
| ks_word | input | 32 | Keystream word from the generator |
| done | output | 1 | One-cycle pulse: chunk finished, window refilled |
| gen_restart | input | 1 | Generator restarted; clear tag (idle only) |
| pair_we | input | 1 | Restore write of {w0, w1} |
| pair_wdata | input | 64 | Data for `pair_we` |
| tail_we | input | 1 | Restore write of w2 |
| tail_wdata | input | 64 | Data for `tail_we`, low 32 bits used |
| tag_we | input | 1 | Restore write of the tag |
| tag_wdata | input | 64 | Data for `tag_we`, low 32 bits used |
| win_pair | output | 64 | Save view {w0, w1} |
| win_tail | output | 64 | Save view, w2 in low half |
| tag_word | output | 64 | Save view, tag in low half |

## Verification
The assertions assume that the generator drives `ks_word` whenever it raises `ks_ack`, and that it raises `ks_ack` only while `ks_req` is high. The bench responder keeps to this: it answers a pending request only, after a programmable stall, and uses a fresh word for every grant. The assertions also assume that restore writes and restarts land only when the host sees `msg_ready`. The one exception is a deliberate check that writes issued while busy are dropped, and the window and tag assertions allow for it. Expected tags come from a bench model of the window that follows the slice formula in R2 and is fed the same keystream sequence.

// File: rtl/zmac_pkg.sv
package zmac_pkg;

    parameter int ZM_WORD_W = 32;
    parameter int ZM_MSG_W  = 64;
    parameter int ZM_WIN_W  = 3 * ZM_WORD_W;
    parameter int ZM_OFF_W  = $clog2(ZM_MSG_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_DONE
    } zm_state_e;

    typedef struct packed {
        logic [ZM_WORD_W-1:0] w0;
        logic [ZM_WORD_W-1:0] w1;
        logic [ZM_WORD_W-1:0] w2;
    } zm_win_t;

    function automatic logic [ZM_MSG_W-1:0] zm_widen(input logic [ZM_WORD_W-1:0] v);
        return {{(ZM_MSG_W-ZM_WORD_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/zmac_slice_lane.sv
module zmac_slice_lane
    import zmac_pkg::*;
(
    input  zm_win_t               win,
    input  logic [ZM_OFF_W-1:0]   offset,
    input  logic                  take,
    output logic [ZM_WORD_W-1:0]  slice
);

    logic [ZM_WIN_W-1:0] flat;
    logic [ZM_WIN_W-1:0] shifted;

    assign flat    = {win.w0, win.w1, win.w2};
    assign shifted = flat << offset;
    assign slice   = take ? shifted[ZM_WIN_W-1 -: ZM_WORD_W] : '0;

endmodule

// File: rtl/zmac_ctrl.sv
module zmac_ctrl
    import zmac_pkg::*;
#(
    parameter int GROUP = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 msg_valid,
    input  logic [ZM_MSG_W-1:0]  msg_data,
    input  logic                 ks_ack,
    output logic                 msg_ready,
    output logic                 ks_req,
    output logic                 done,
    output logic                 scan_en,
    output logic [GROUP-1:0]     grp_bits,
    output logic [ZM_OFF_W-1:0]  grp_base,
    output logic                 fill_first,
    output logic                 fill_second,
    output logic                 idle
);

    localparam int STEPS = ZM_MSG_W / GROUP;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    zm_state_e           state;
    logic [CNT_W-1:0]    step;
    logic [ZM_MSG_W-1:0] shreg;
    logic                last_step;

    assign idle        = (state == ST_IDLE);
    assign msg_ready   = idle;
    assign scan_en     = (state == ST_SCAN);
    assign ks_req      = (state == ST_FETCH_A) || (state == ST_FETCH_B);
    assign done        = (state == ST_DONE);
    assign fill_first  = (state == ST_FETCH_A) && ks_ack;
    assign fill_second = (state == ST_FETCH_B) && ks_ack;
    assign grp_bits    = shreg[ZM_MSG_W-1 -: GROUP];
    assign grp_base    = ZM_OFF_W'(32'(step) * GROUP);
    assign last_step   = (32'(step) == STEPS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            shreg <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (msg_valid) begin
                        state <= ST_SCAN;
                        step  <= '0;
                        shreg <= msg_data;
                    end
                end
                ST_SCAN: begin
                    shreg <= shreg << GROUP;
                    if (last_step) begin
                        state <= ST_FETCH_A;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_FETCH_A: if (ks_ack) state <= ST_FETCH_B;
                ST_FETCH_B: if (ks_ack) state <= ST_DONE;
                ST_DONE:    state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/zmac_window.sv
module zmac_window
    import zmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idle,
    input  logic                 fill_first,
    input  logic                 fill_second,
    input  logic [ZM_WORD_W-1:0] ks_word,
    input  logic                 pair_we,
    input  logic [ZM_MSG_W-1:0]  pair_wdata,
    input  logic                 tail_we,
    input  logic [ZM_MSG_W-1:0]  tail_wdata,
    output zm_win_t              win
);

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (fill_first) begin
            win.w0 <= win.w2;
            win.w1 <= ks_word;
        end else if (fill_second) begin
            win.w2 <= ks_word;
        end else if (idle) begin
            if (pair_we) begin
                win.w0 <= pair_wdata[ZM_MSG_W-1 -: ZM_WORD_W];
                win.w1 <= pair_wdata[ZM_WORD_W-1:0];
            end
            if (tail_we) begin
                win.w2 <= tail_wdata[ZM_WORD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/zmac_tag.sv
module zmac_tag
    import zmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idle,
    input  logic                 restart,
    input  logic                 tag_we,
    input  logic [ZM_MSG_W-1:0]  tag_wdata,
    input  logic                 scan_en,
    input  logic [ZM_WORD_W-1:0] fold,
    output logic [ZM_WORD_W-1:0] tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag <= '0;
        end else if (idle && restart) begin
            tag <= '0;
        end else if (idle && tag_we) begin
            tag <= tag_wdata[ZM_WORD_W-1:0];
        end else if (scan_en) begin
            tag <= tag ^ fold;
        end
    end

endmodule

// File: rtl/zmac_accum.sv
module zmac_accum
    import zmac_pkg::*;
#(
    parameter int GROUP_BITS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        msg_valid,
    input  logic [63:0] msg_data,
    output logic        msg_ready,
    output logic        ks_req,
    input  logic        ks_ack,
    input  logic [31:0] ks_word,
    output logic        done,
    input  logic        gen_restart,
    input  logic        pair_we,
    input  logic [63:0] pair_wdata,
    input  logic        tail_we,
    input  logic [63:0] tail_wdata,
    input  logic        tag_we,
    input  logic [63:0] tag_wdata,
    output logic [63:0] win_pair,
    output logic [63:0] win_tail,
    output logic [63:0] tag_word
);

    zm_win_t                 win;
    logic                    scan_en;
    logic                    fill_first;
    logic                    fill_second;
    logic                    idle;
    logic [GROUP_BITS-1:0]   grp_bits;
    logic [ZM_OFF_W-1:0]     grp_base;
    logic [ZM_WORD_W-1:0]    lane_slice [GROUP_BITS];
    logic [ZM_WORD_W-1:0]    fold;
    logic [ZM_WORD_W-1:0]    tag;

    zmac_ctrl #(.GROUP(GROUP_BITS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .msg_valid   (msg_valid),
        .msg_data    (msg_data),
        .ks_ack      (ks_ack),
        .msg_ready   (msg_ready),
        .ks_req      (ks_req),
        .done        (done),
        .scan_en     (scan_en),
        .grp_bits    (grp_bits),
        .grp_base    (grp_base),
        .fill_first  (fill_first),
        .fill_second (fill_second),
        .idle        (idle)
    );

    zmac_window u_win (
        .clk         (clk),
        .rst         (rst),
        .idle        (idle),
        .fill_first  (fill_first),
        .fill_second (fill_second),
        .ks_word     (ks_word),
        .pair_we     (pair_we),
        .pair_wdata  (pair_wdata),
        .tail_we     (tail_we),
        .tail_wdata  (tail_wdata),
        .win         (win)
    );

    for (genvar j = 0; j < GROUP_BITS; j++) begin : g_lane
        zmac_slice_lane u_lane (
            .win    (win),
            .offset (grp_base + ZM_OFF_W'(j)),
            .take   (grp_bits[GROUP_BITS-1-j]),
            .slice  (lane_slice[j])
        );
    end

    always_comb begin
        fold = '0;
        for (int j = 0; j < GROUP_BITS; j++) begin
            fold = fold ^ lane_slice[j];
        end
    end

    zmac_tag u_tag (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .restart   (gen_restart),
        .tag_we    (tag_we),
        .tag_wdata (tag_wdata),
        .scan_en   (scan_en),
        .fold      (fold),
        .tag       (tag)
    );

    assign win_pair = {win.w0, win.w1};
    assign win_tail = zm_widen(win.w2);
    assign tag_word = zm_widen(tag);

endmodule

// File: rtl/zmac_accum_chk.sv
module zmac_accum_chk (
    input logic        clk,
    input logic        rst,
    input logic        msg_ready,
    input logic        ks_req,
    input logic        ks_ack,
    input logic [31:0] ks_word,
    input logic        done,
    input logic        gen_restart,
    input logic [63:0] win_pair,
    input logic [63:0] win_tail,
    input logic [63:0] tag_word
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (msg_ready && !ks_req && !done && tag_word == 64'd0));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ks_req && !ks_ack) |=> ks_req);

    // R5
    done_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ks_req && ks_ack));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    busy_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ks_req |-> !msg_ready);

    // R4
    word_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (ks_req && ks_ack) |=> (win_pair[31:0] == $past(ks_word) ||
                                win_tail[31:0] == $past(ks_word)));

    // R8
    window_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!msg_ready && !ks_req && !done) |=> ($stable(win_pair) && $stable(win_tail)));

    // R3
    tag_frozen_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ks_req |=> $stable(tag_word));

    // R9
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_ready && gen_restart) |=> tag_word == 64'd0);

endmodule

bind zmac_accum zmac_accum_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .msg_ready   (msg_ready),
    .ks_req      (ks_req),
    .ks_ack      (ks_ack),
    .ks_word     (ks_word),
    .done        (done),
    .gen_restart (gen_restart),
    .win_pair    (win_pair),
    .win_tail    (win_tail),
    .tag_word    (tag_word)
);

// File: tb/sim_zmac_accum.sv
module sim_zmac_accum;

    logic        clk = 1'b0;
    logic        rst;
    logic        msg_valid;
    logic [63:0] msg_data;
    logic        msg_ready;
    logic        ks_req;
    logic        ks_ack;
    logic [31:0] ks_word;
    logic        done;
    logic        gen_restart;
    logic        pair_we;
    logic [63:0] pair_wdata;
    logic        tail_we;
    logic [63:0] tail_wdata;
    logic        tag_we;
    logic [63:0] tag_wdata;
    logic [63:0] win_pair;
    logic [63:0] win_tail;
    logic [63:0] tag_word;

    int n_run  = 0;
    int n_fail = 0;
    int stall_cyc = 0;
    int grants = 0;
    int resp_idx = 0;
    int resp_wait = 0;
    bit finished = 0;

    logic [31:0] m_w0, m_w1, m_w2, m_tag;
    int m_idx = 0;

    always #5 clk = ~clk;

    zmac_accum u0 (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_data(msg_data),
        .msg_ready(msg_ready), .ks_req(ks_req), .ks_ack(ks_ack), .ks_word(ks_word),
        .done(done), .gen_restart(gen_restart), .pair_we(pair_we), .pair_wdata(pair_wdata),
        .tail_we(tail_we), .tail_wdata(tail_wdata), .tag_we(tag_we), .tag_wdata(tag_wdata),
        .win_pair(win_pair), .win_tail(win_tail), .tag_word(tag_word)
    );

    function automatic logic [31:0] kw(input int n);
        logic [31:0] v;
        v = 32'(n + 1) * 32'h9E37_79B9;
        return v ^ {16'(n), 16'h5A3C} ^ (v >> 13);
    endfunction

    function automatic logic [31:0] ref_slice(input int i);
        if (i == 0)       return m_w0;
        else if (i < 32)  return (m_w0 << i) | (m_w1 >> (32 - i));
        else if (i == 32) return m_w1;
        else              return (m_w1 << (i - 32)) | (m_w2 >> (64 - i));
    endfunction

    // keystream responder: answers only a pending request
    initial begin
        ks_ack  = 1'b0;
        ks_word = '0;
        forever begin
            @(negedge clk);
            if (ks_ack) resp_idx++;
            ks_ack = 1'b0;
            if (ks_req && !rst) begin
                if (resp_wait >= stall_cyc) begin
                    ks_ack    = 1'b1;
                    ks_word   = kw(resp_idx);
                    grants++;
                    resp_wait = 0;
                end else begin
                    resp_wait++;
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_chunk(input logic [63:0] m);
        for (int i = 0; i < 64; i++) begin
            if (m[63 - i]) m_tag = m_tag ^ ref_slice(i);
        end
        m_w0 = m_w2;
        m_w1 = kw(m_idx);
        m_w2 = kw(m_idx + 1);
        m_idx += 2;
    endtask

    task automatic check_state(input string req);
        check(req, tag_word, {32'd0, m_tag});
        check(req, win_pair, {m_w0, m_w1});
        check(req, win_tail, {32'd0, m_w2});
    endtask

    task automatic run_chunk(input logic [63:0] m, input string req);
        int g0;
        bit seen;
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        msg_valid = 1'b1;
        msg_data  = m;
        g0 = grants;
        @(negedge clk);
        msg_valid = 1'b0;
        check({req, " ready low after accept"}, {63'd0, msg_ready}, 64'd0);
        seen = 0;
        for (int k = 0; k < 400 && !seen; k++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        check({req, " R5 done seen"}, {63'd0, seen}, 64'd1);
        check({req, " R5 two grants"}, 64'(grants - g0), 64'd2);
        @(negedge clk);
        check({req, " R5 done one cycle"}, {63'd0, done}, 64'd0);
        model_chunk(m);
    endtask

    task automatic load_window(input logic [31:0] a, input logic [31:0] b,
                               input logic [31:0] c, input logic [31:0] t);
        @(negedge clk);
        pair_we = 1'b1; pair_wdata = {a, b};
        tail_we = 1'b1; tail_wdata = {32'hDEAD_BEEF, c};
        tag_we  = 1'b1; tag_wdata  = {32'hFFFF_FFFF, t};
        @(negedge clk);
        pair_we = 1'b0; tail_we = 1'b0; tag_we = 1'b0;
        m_w0 = a; m_w1 = b; m_w2 = c; m_tag = t;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tag", tag_word, 64'd0);
        check("R1 pair", win_pair, 64'd0);
        check("R1 tail", win_tail, 64'd0);
        check("R1 ready/req/done", {61'd0, msg_ready, ks_req, done}, 64'b100);
        m_w0 = 0; m_w1 = 0; m_w2 = 0; m_tag = 0;
    endtask

    task automatic t_restore;
        load_window(32'h0123_4567, 32'h89AB_CDEF, 32'hF0E1_D2C3, 32'h1357_9BDF);
        check_state("R7 R8 restore view");
    endtask

    task automatic t_single_bits;
        load_window(32'hA5A5_0F0F, 32'h3C3C_9696, 32'h1111_2222, 32'h0);
        run_chunk(64'h8000_0000_0000_0000, "R2 offset0");
        check("R2 offset0 tag=w0", tag_word, 64'h0000_0000_A5A5_0F0F);
        check_state("R4 advance offset0");
        load_window(32'hA5A5_0F0F, 32'h3C3C_9696, 32'h1111_2222, 32'h0);
        run_chunk(64'h0000_0000_8000_0000, "R2 offset32");
        check("R2 offset32 tag=w1", tag_word, 64'h0000_0000_3C3C_9696);
        load_window(32'hA5A5_0F0F, 32'h3C3C_9696, 32'h1111_2222, 32'h0);
        run_chunk(64'h0000_0800_0000_0001, "R2 mid offsets");
        check_state("R2 offsets 20 and 63");
    endtask

    task automatic t_patterns;
        logic [63:0] pats [6];
        pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[1] = 64'hAAAA_5555_0F0F_F0F0;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        pats[3] = 64'h8000_0001_8000_0001;
        pats[4] = 64'hDEAD_BEEF_CAFE_F00D;
        pats[5] = 64'h7FFF_FFFF_FFFF_FFFE;
        for (int p = 0; p < 6; p++) begin
            stall_cyc = p % 3;
            run_chunk(pats[p], "R3 pattern");
            check_state("R3 R4 chained chunk");
        end
        stall_cyc = 0;
    endtask

    task automatic t_zero;
        logic [31:0] t0;
        t0 = m_tag;
        run_chunk(64'd0, "R3 zero chunk");
        check("R3 zero chunk tag unchanged", tag_word, {32'd0, t0});
        check_state("R4 zero chunk advances");
    endtask

    task automatic t_busy;
        bit rdy_seen;
        @(negedge clk);
        msg_valid = 1'b1;
        msg_data  = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        msg_data  = 64'hFFFF_0000_FFFF_0000;
        rdy_seen  = 0;
        pair_we = 1'b1; pair_wdata = 64'h5555_5555_5555_5555;
        tag_we  = 1'b1; tag_wdata  = 64'h0000_0000_7777_7777;
        tail_we = 1'b1; tail_wdata = 64'h0000_0000_6666_6666;
        for (int k = 0; k < 4; k++) begin
            if (msg_ready) rdy_seen = 1;
            @(negedge clk);
        end
        pair_we = 1'b0; tag_we = 1'b0; tail_we = 1'b0;
        msg_valid = 1'b0;
        check("R6 ready low while busy", {63'd0, rdy_seen}, 64'd0);
        while (!done) @(negedge clk);
        @(negedge clk);
        model_chunk(64'h1234_5678_9ABC_DEF0);
        check_state("R6 R8 busy inputs ignored");
    endtask

    task automatic t_restart;
        logic [31:0] a, b, c;
        a = m_w0; b = m_w1; c = m_w2;
        @(negedge clk);
        gen_restart = 1'b1;
        tag_we = 1'b1; tag_wdata = 64'h0000_0000_ABCD_0123;
        @(negedge clk);
        gen_restart = 1'b0; tag_we = 1'b0;
        m_tag = 0;
        check("R9 restart clears tag", tag_word, 64'd0);
        check("R9 window kept pair", win_pair, {a, b});
        check("R9 window kept tail", win_tail, {32'd0, c});
    endtask

    initial begin
        rst = 1'b1; msg_valid = 1'b0; msg_data = '0; gen_restart = 1'b0;
        pair_we = 1'b0; pair_wdata = '0; tail_we = 1'b0; tail_wdata = '0;
        tag_we = 1'b0; tag_wdata = '0;
        t_reset();
        t_restore();
        t_single_bits();
        t_patterns();
        t_zero();
        t_busy();
        t_restart();
        run_chunk(64'hC3C3_3C3C_A5A5_5A5A, "R3 after restart");
        check_state("R3 after restart");
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule